// File: doc/BRIEF.md
# Host I/O and Memory Cycle Decoder

This block decides whether a host I/O or memory cycle should be steered to the serial peripheral link. A small register port holds the programming. That programming covers three fixed legacy I/O ports, four generic I/O windows and four generic memory windows, plus one decode-enable register. Each fixed port has its own enable bit. Each generic window has its own base, its own size field and its own enable bit.

A lookup port takes an address and a flag that tells I/O from memory. One clock later it returns a hit flag, a flag saying a fixed port claimed the cycle, and the index of the generic window that matched. Every window is compared in parallel. A fixed port beats any generic window. Among generic windows, the lowest enabled index wins. Each size field holds the window size minus one, so a zero field describes a one-byte window.

Top module: `host_decode_top`

## Requirements
- R1: After reset, every enable bit, base and size field is zero, and `res_valid`, `res_hit`, `res_fixed` and `res_idx` are all zero. No lookup hits until something has been programmed.
- R2: `res_valid` equals `lk_valid` delayed by one clock. In any cycle where `res_valid` is low, `res_hit`, `res_fixed` and `res_idx` are zero.
- R3: An I/O lookup of address 0x80 hits with `res_fixed`=1 and `res_idx`=0 when bit 0 of the enable register is set.
- R4: With bit 1 of the enable register set, I/O addresses 0x60 and 0x64 both hit as fixed. Addresses 0x61 to 0x63 are not claimed by that bit.
- R5: With bit 2 of the enable register set, I/O addresses 0x2E and 0x2F both hit as fixed. Address 0x30 is not claimed.
- R6: Generic I/O window i has a 16-bit base at register index 0x10+2i and an 8-bit size field at index 0x11+2i. It matches an address a when base <= a <= base+field, computed without wrapping past 0xFFFF.
- R7: Generic memory window i has a 32-bit base at register index 0x20+2i and a 16-bit size field at index 0x21+2i. It matches an address a when base <= a <= base+field, computed without wrapping past 0xFFFFFFFF.
- R8: I/O window i takes part in matching only while enable bit 3+i is set. Memory window i takes part only while enable bit 7+i is set.
- R9: A write to the enable register (index 0x00) ORs the written data into it, so bits that are already set stay set until reset.
- R10: A fixed port takes priority over a generic window. Among matching generic windows, the lowest index wins. `res_idx` is 0 whenever `res_fixed` is 1. A memory lookup never matches a fixed port.
- R11: An I/O lookup uses only `lk_addr[15:0]`. The upper address bits have no effect on the result.
- R12: A base or size write is used by the very next lookup. A write to a register index that is not mapped changes no decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index being written |
| wr_data | input | 32 | Register write data |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_is_mem | input | 1 | 1 = memory lookup, 0 = I/O lookup |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | A result is present (one cycle after the lookup) |
| res_hit | output | 1 | The cycle belongs to the link |
| res_fixed | output | 1 | A fixed legacy port claimed the cycle |
| res_idx | output | 2 | Index of the winning generic window |

## Verification
The assertions assume that `rst` is held high from time zero through at least one clock edge. They also assume that `lk_valid`, `lk_is_mem` and `wr_en` are never X while out of reset. The bench meets these assumptions by driving every input to a known value before the first edge and changing inputs only on the falling edge. Register writes and lookups are kept in separate cycles. This way each expected result reflects programming that has fully settled, and each lookup shows up on the outputs exactly one edge later.

// File: rtl/hdec_pkg.sv
package hdec_pkg;
  // enable register bit positions for the fixed legacy ports
  localparam int FIX_N    = 3;
  localparam int FIX_POST = 0;
  localparam int FIX_KBD  = 1;
  localparam int FIX_CFG  = 2;

  // fixed legacy I/O addresses
  localparam logic [15:0] PORT_POST  = 16'h0080;
  localparam logic [15:0] PORT_KBD_A = 16'h0060;
  localparam logic [15:0] PORT_KBD_B = 16'h0064;
  localparam logic [15:0] PORT_CFG_A = 16'h002E;
  localparam logic [15:0] PORT_CFG_B = 16'h002F;

  // register index map
  localparam int REG_EN       = 'h00;
  localparam int REG_IO_BASE  = 'h10;  // base at +2i, size at +2i+1
  localparam int REG_MEM_BASE = 'h20;
endpackage

// File: rtl/hdec_regs.sv
module hdec_regs
  import hdec_pkg::*;
#(
  parameter int NIO    = 4,
  parameter int NMEM   = 4,
  parameter int IO_AW  = 16,
  parameter int IO_SW  = 8,
  parameter int MEM_AW = 32,
  parameter int MEM_SW = 16,
  parameter int RIDX_W = 8,
  parameter int DW     = 32,
  localparam int EN_W  = FIX_N + NIO + NMEM
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [RIDX_W-1:0]                 wr_idx,
  input  logic [DW-1:0]                     wr_data,
  output logic [EN_W-1:0]                   en,
  output logic [NIO-1:0][IO_AW-1:0]         io_base,
  output logic [NIO-1:0][IO_SW-1:0]         io_size,
  output logic [NMEM-1:0][MEM_AW-1:0]       mem_base,
  output logic [NMEM-1:0][MEM_SW-1:0]       mem_size
);

  // enable register: writes only ever add bits
  always_ff @(posedge clk) begin
    if (rst) begin
      en <= '0;
    end else if (wr_en && wr_idx == RIDX_W'(REG_EN)) begin
      en <= en | wr_data[EN_W-1:0];
    end
  end

  for (genvar i = 0; i < NIO; i++) begin : g_io
    localparam int BI = REG_IO_BASE + 2 * i;
    always_ff @(posedge clk) begin
      if (rst) begin
        io_base[i] <= '0;
        io_size[i] <= '0;
      end else if (wr_en) begin
        if (wr_idx == RIDX_W'(BI))     io_base[i] <= wr_data[IO_AW-1:0];
        if (wr_idx == RIDX_W'(BI + 1)) io_size[i] <= wr_data[IO_SW-1:0];
      end
    end
  end

  for (genvar i = 0; i < NMEM; i++) begin : g_mem
    localparam int BI = REG_MEM_BASE + 2 * i;
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_base[i] <= '0;
        mem_size[i] <= '0;
      end else if (wr_en) begin
        if (wr_idx == RIDX_W'(BI))     mem_base[i] <= wr_data[MEM_AW-1:0];
        if (wr_idx == RIDX_W'(BI + 1)) mem_size[i] <= wr_data[MEM_SW-1:0];
      end
    end
  end

endmodule

// File: rtl/hdec_fixed_ports.sv
module hdec_fixed_ports
  import hdec_pkg::*;
(
  input  logic [15:0]      addr,
  input  logic [FIX_N-1:0] en,
  output logic             hit
);
  logic post_m, kbd_m, cfg_m;

  always_comb begin
    post_m = (addr == PORT_POST);
    kbd_m  = (addr == PORT_KBD_A) || (addr == PORT_KBD_B);
    cfg_m  = (addr == PORT_CFG_A) || (addr == PORT_CFG_B);
    hit    = (en[FIX_POST] && post_m) || (en[FIX_KBD] && kbd_m) ||
             (en[FIX_CFG] && cfg_m);
  end
endmodule

// File: rtl/hdec_win_match.sv
module hdec_win_match #(
  parameter int N     = 4,
  parameter int AW    = 16,
  parameter int SW    = 8,
  parameter int IDX_W = 2
) (
  input  logic [AW-1:0]         addr,
  input  logic [N-1:0][AW-1:0]  base,
  input  logic [N-1:0][SW-1:0]  size,
  input  logic [N-1:0]          en,
  output logic                  any_hit,
  output logic [IDX_W-1:0]      idx
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [AW-1:0] diff;
    logic          above;
    always_comb begin
      above  = (addr >= base[i]);
      diff   = addr - base[i];
      hit[i] = en[i] && above && (diff <= AW'(size[i]));
    end
  end

  // lowest index wins: scan from the top so the lowest hit is written last
  always_comb begin
    any_hit = 1'b0;
    idx     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        idx     = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/host_decode_top.sv
module host_decode_top
  import hdec_pkg::*;
#(
  parameter int NIO    = 4,
  parameter int NMEM   = 4,
  parameter int IO_SW  = 8,
  parameter int MEM_AW = 32,
  parameter int MEM_SW = 16,
  parameter int RIDX_W = 8,
  parameter int DW     = 32,
  localparam int IO_AW = 16,
  localparam int EN_W  = FIX_N + NIO + NMEM,
  localparam int NMAX  = (NIO > NMEM) ? NIO : NMEM,
  localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              lk_valid,
  input  logic              lk_is_mem,
  input  logic [MEM_AW-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_fixed,
  output logic [IDX_W-1:0]  res_idx
);

  logic [EN_W-1:0]             dec_en;
  logic [NIO-1:0][IO_AW-1:0]   io_base;
  logic [NIO-1:0][IO_SW-1:0]   io_size;
  logic [NMEM-1:0][MEM_AW-1:0] mem_base;
  logic [NMEM-1:0][MEM_SW-1:0] mem_size;

  hdec_regs #(
    .NIO(NIO), .NMEM(NMEM), .IO_AW(IO_AW), .IO_SW(IO_SW),
    .MEM_AW(MEM_AW), .MEM_SW(MEM_SW), .RIDX_W(RIDX_W), .DW(DW)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .en(dec_en), .io_base(io_base), .io_size(io_size),
    .mem_base(mem_base), .mem_size(mem_size)
  );

  logic fx_hit;
  hdec_fixed_ports u_fixed (
    .addr(lk_addr[IO_AW-1:0]),
    .en  (dec_en[FIX_N-1:0]),
    .hit (fx_hit)
  );

  logic             io_any, mem_any;
  logic [IDX_W-1:0] io_idx, mem_idx;

  hdec_win_match #(.N(NIO), .AW(IO_AW), .SW(IO_SW), .IDX_W(IDX_W)) u_io_match (
    .addr(lk_addr[IO_AW-1:0]), .base(io_base), .size(io_size),
    .en(dec_en[FIX_N +: NIO]), .any_hit(io_any), .idx(io_idx)
  );

  hdec_win_match #(.N(NMEM), .AW(MEM_AW), .SW(MEM_SW), .IDX_W(IDX_W)) u_mem_match (
    .addr(lk_addr), .base(mem_base), .size(mem_size),
    .en(dec_en[FIX_N + NIO +: NMEM]), .any_hit(mem_any), .idx(mem_idx)
  );

  logic             fixed_win, gen_win;
  logic [IDX_W-1:0] gen_idx;

  always_comb begin
    fixed_win = !lk_is_mem && fx_hit;
    gen_win   = lk_is_mem ? mem_any : io_any;
    gen_idx   = lk_is_mem ? mem_idx : io_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fixed <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && (fixed_win || gen_win);
      res_fixed <= lk_valid && fixed_win;
      res_idx   <= (lk_valid && !fixed_win && gen_win) ? gen_idx : '0;
    end
  end

endmodule

// File: rtl/hdec_chk.sv
module hdec_chk #(
  parameter int EN_W  = 11,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_is_mem,
  input logic [EN_W-1:0]  en,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_fixed,
  input logic [IDX_W-1:0] res_idx
);

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  a_r2_idle_delay: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  a_r2_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && !res_fixed && res_idx == '0));

  a_r10_fixed_implies_hit: assert property (@(posedge clk) disable iff (rst)
    res_fixed |-> (res_hit && res_idx == '0));

  a_r10_mem_never_fixed: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_is_mem) |=> !res_fixed);

  a_r9_enables_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en & $past(en)) == $past(en)));

endmodule

bind host_decode_top hdec_chk #(.EN_W(EN_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_is_mem(lk_is_mem),
  .en(dec_en), .res_valid(res_valid), .res_hit(res_hit),
  .res_fixed(res_fixed), .res_idx(res_idx)
);

// File: tb/host_decode_top_bench.sv
module host_decode_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;
  localparam int VW = 37;  // {is_mem, addr[31:0], hit, fixed, idx[1:0]}

  // expected results under the programming done in the setup phase
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 32'h0000_0080, 1'b1, 1'b1, 2'd0},  // R3
    {1'b0, 32'h0000_0060, 1'b1, 1'b1, 2'd0},  // R4
    {1'b0, 32'h0000_0064, 1'b1, 1'b1, 2'd0},  // R4
    {1'b0, 32'h0000_0062, 1'b1, 1'b0, 2'd3},  // R4 R10 window 3 only
    {1'b0, 32'h0000_002E, 1'b1, 1'b1, 2'd0},  // R5
    {1'b0, 32'h0000_002F, 1'b1, 1'b1, 2'd0},  // R5
    {1'b0, 32'h0000_0400, 1'b1, 1'b0, 2'd0},  // R6
    {1'b0, 32'h0000_040A, 1'b1, 1'b0, 2'd0},  // R10 overlap
    {1'b0, 32'h0000_0410, 1'b1, 1'b0, 2'd1},  // R6
    {1'b0, 32'h0000_0447, 1'b1, 1'b0, 2'd1},  // R6 top edge
    {1'b0, 32'h0000_0448, 1'b0, 1'b0, 2'd0},  // R6 past top
    {1'b0, 32'h0000_03FF, 1'b0, 1'b0, 2'd0},  // R6 below base
    {1'b0, 32'h0000_FFFF, 1'b1, 1'b0, 2'd2},  // R6
    {1'b0, 32'h0000_0000, 1'b0, 1'b0, 2'd0},  // R6 no wrap
    {1'b0, 32'h0000_00EF, 1'b0, 1'b0, 2'd0},  // R6 no wrap
    {1'b0, 32'h0001_0080, 1'b1, 1'b1, 2'd0},  // R11
    {1'b1, 32'h0000_0080, 1'b0, 1'b0, 2'd0},  // R10 mem never fixed
    {1'b1, 32'hFED0_0000, 1'b1, 1'b0, 2'd0},  // R7
    {1'b1, 32'hFED0_0FFF, 1'b1, 1'b0, 2'd0},  // R10 overlap
    {1'b1, 32'hFED0_1000, 1'b1, 1'b0, 2'd1},  // R7
    {1'b1, 32'hFED1_07FF, 1'b1, 1'b0, 2'd1},  // R7 top edge
    {1'b1, 32'hFED1_0800, 1'b0, 1'b0, 2'd0},  // R7 past top
    {1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'd2},  // R7
    {1'b1, 32'h0000_0000, 1'b0, 1'b0, 2'd0},  // R7 no wrap
    {1'b1, 32'h0000_1000, 1'b0, 1'b0, 2'd0},  // R8 window disabled
    {1'b1, 32'hFECF_FFFF, 1'b0, 1'b0, 2'd0},  // R7 below base
    {1'b0, 32'h0000_0081, 1'b0, 1'b0, 2'd0},  // R3
    {1'b0, 32'h0000_0030, 1'b0, 1'b0, 2'd0}   // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        lk_valid = 1'b0;
  logic        lk_is_mem = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_fixed;
  logic [1:0]  res_idx;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  host_decode_top u_host_decode_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_is_mem(lk_is_mem), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_fixed(res_fixed),
    .res_idx(res_idx)
  );

  task automatic wr(input logic [7:0] idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input string req, input logic v, input logic h,
                       input logic f, input logic [1:0] i, input logic ev,
                       input logic eh, input logic ef, input logic [1:0] ei);
    n_checks++;
    if ({v, h, f, i} !== {ev, eh, ef, ei}) begin
      n_fail++;
      $display("FAIL %s: got valid=%b hit=%b fixed=%b idx=%0d, expected valid=%b hit=%b fixed=%b idx=%0d",
               req, v, h, f, i, ev, eh, ef, ei);
    end
  endtask

  // present one lookup, sample the registered result after the next edge
  task automatic look(input string req, input logic is_mem, input logic [31:0] a,
                      input logic eh, input logic ef, input logic [1:0] ei);
    @(negedge clk);
    lk_valid = 1'b1; lk_is_mem = is_mem; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, res_valid, res_hit, res_fixed, res_idx, 1'b1, eh, ef, ei);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs clear while and after reset
    check("R1", res_valid, res_hit, res_fixed, res_idx, 1'b0, 1'b0, 1'b0, 2'd0);
    rst = 1'b0;
    look("R1", 1'b0, 32'h80, 1'b0, 1'b0, 2'd0);
    look("R1", 1'b1, 32'h0, 1'b0, 1'b0, 2'd0);

    // program windows
    wr(8'h10, 32'h0000_0400); wr(8'h11, 32'h0F);
    wr(8'h12, 32'h0000_0408); wr(8'h13, 32'h3F);
    wr(8'h14, 32'h0000_FFF0); wr(8'h15, 32'hFF);
    wr(8'h16, 32'h0000_0060); wr(8'h17, 32'h0F);
    wr(8'h20, 32'hFED0_0000); wr(8'h21, 32'h0FFF);
    wr(8'h22, 32'hFED0_0800); wr(8'h23, 32'hFFFF);
    wr(8'h24, 32'hFFFF_FFF0); wr(8'h25, 32'hFFFF);
    wr(8'h26, 32'h0000_1000); wr(8'h27, 32'h0);
    // R9: enables built up by three separate OR writes
    wr(8'h00, 32'h007);
    wr(8'h00, 32'h078);
    wr(8'h00, 32'h380);

    for (int k = 0; k < NV; k++) begin
      look("R3-vector", VEC[k][36], VEC[k][35:4], VEC[k][3], VEC[k][2], VEC[k][1:0]);
    end

    // R2: no lookup -> no result even with a claimable address
    @(negedge clk);
    lk_valid = 1'b0; lk_is_mem = 1'b0; lk_addr = 32'h80;
    @(negedge clk);
    check("R2", res_valid, res_hit, res_fixed, res_idx, 1'b0, 1'b0, 1'b0, 2'd0);

    // R9/R8: enabling memory window 3 keeps every earlier enable
    wr(8'h00, 32'h400);
    look("R8", 1'b1, 32'h0000_1000, 1'b1, 1'b0, 2'd3);
    look("R9", 1'b0, 32'h80, 1'b1, 1'b1, 2'd0);
    look("R9", 1'b0, 32'h0400, 1'b1, 1'b0, 2'd0);

    // R12: shrink I/O window 0 to one byte, used by the next lookup
    wr(8'h11, 32'h00);
    look("R12", 1'b0, 32'h0400, 1'b1, 1'b0, 2'd0);
    look("R12", 1'b0, 32'h0401, 1'b0, 1'b0, 2'd0);

    // R12: unmapped index write changes nothing
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h3F, 32'hFFFF_FFFF);
    look("R12", 1'b0, 32'h0401, 1'b0, 1'b0, 2'd0);
    look("R12", 1'b1, 32'hFED1_0800, 1'b0, 1'b0, 2'd0);
    look("R12", 1'b0, 32'h0000_0030, 1'b0, 1'b0, 2'd0);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R1", 1'b0, 32'h80, 1'b0, 1'b0, 2'd0);
    look("R1", 1'b1, 32'hFED0_0000, 1'b0, 1'b0, 2'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got no finish, expected finish within 20000 cycles");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule